// File: doc/BRIEF.md
# Memory Burst Boundary Splitter

This block sits between a bus-side transaction queue and a memory controller's pin sequencer. It accepts one burst descriptor at a time and turns it into a series of memory-side burst commands. A descriptor carries a byte address, a beat count, a beat size, a direction and a target chip. The block converts the byte address into a word address for the target chip's memory width. It counts the total number of memory words to move. It then issues commands, each a word address and a beat count, until the whole transfer has been handed off.

Three limits bound each command. The first is the chip's programmed burst length. The second is the distance to the next burst-length boundary, and it applies only when that chip has alignment enabled. The third is a ceiling set by the data FIFOs. For reads, the ceiling is the read FIFO depth. For writes, it is the write FIFO depth scaled by the ratio of the bus beat size to the memory width. A chip programmed for continuous bursts has no burst length and no boundary, so only the FIFO ceiling applies to it.

Per-chip configuration is taken from static inputs when a descriptor is accepted, and it stays fixed until that descriptor is finished. Every command is passed on through a ready/valid handshake.

Top module: `mem_burst_splitter`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `cmd_valid_o` is 0.
- R2: The first command's word address is the request byte address shifted right by the chip's width code (0=8, 1=16, 2=32, 3=64 bit). Each following command's address is the previous address plus the previous beat count.
- R3: The beat counts of a descriptor's commands add up to ((len+1) << size) >> width code, where `req_len_i` holds beats minus one and `req_size_i` holds log2 of the bytes per beat. A result of zero is raised to one.
- R4: When the chip's burst code is 0 to 5, no command is longer than 1 << code beats.
- R5: With the chip's align bit set and a burst code of 0 to 5, no command crosses a word address that is a multiple of 1 << code.
- R6: With the align bit clear, a command is cut short only by the burst length, the FIFO ceiling or the end of the transfer.
- R7: A read command (`req_write_i`=0) is never longer than RFIFO_DEPTH beats.
- R8: A write command is never longer than max(1, (WFIFO_DEPTH << size) >> width code) beats.
- R9: Burst codes 6 and 7 mean continuous. Only the FIFO ceiling limits the command, and the align bit has no effect.
- R10: `req_ready_o` is 0 from the cycle after a descriptor is accepted until the handshake of its last command. It returns to 1 in the next cycle.
- R11: While `cmd_valid_o` is 1 and `cmd_ready_i` is 0, every command output holds its value.
- R12: Configuration inputs that change after a descriptor has been accepted do not affect that descriptor's commands.
- R13: Every command carries the descriptor's direction and chip index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Descriptor valid |
| req_ready_o | output | 1 | Descriptor accepted when high with valid |
| req_addr_i | input | ADDR_W | Byte address |
| req_len_i | input | LEN_W | Bus beats minus one |
| req_size_i | input | 3 | log2 of bytes per bus beat |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_chip_i | input | CHIP_W | Target chip index |
| cfg_blen_i | input | 3*NUM_CHIPS | Per-chip burst code; 0..5 give 1 << code beats, 6..7 mean continuous |
| cfg_align_i | input | NUM_CHIPS | Per-chip boundary alignment enable |
| cfg_mw_i | input | 2*NUM_CHIPS | Per-chip memory width code (log2 bytes) |
| cmd_valid_o | output | 1 | Memory command valid |
| cmd_ready_i | input | 1 | Memory command accepted |
| cmd_addr_o | output | ADDR_W | Memory word address |
| cmd_beats_o | output | BEAT_W | Memory beats in this command |
| cmd_write_o | output | 1 | Command direction |
| cmd_chip_o | output | CHIP_W | Command chip index |

## Verification
Some properties are checked on every cycle. Commands are contiguous in word address. A stalled command holds its outputs. Every command respects the burst length, the aligned boundary, and the read and write ceilings. An accepted descriptor always produces a command in the next cycle. The exact split of a transfer can only be shown by the directed scenarios, because it depends on the start offset, the width code and the beat size. The same holds for the insensitivity to configuration changes in mid-transfer and for the ready bubble between two descriptors. Those scenarios compare each command against a model built from the requirements.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
  localparam int unsigned BND_W = 6; // holds the largest burst length, 32

  typedef logic [2:0] blen_code_t;
  typedef logic [1:0] mw_code_t;
  typedef logic [2:0] size_code_t;

  function automatic logic blen_is_cont(blen_code_t c);
    return c > 3'd5;
  endfunction

  function automatic logic [BND_W-1:0] blen_beats(blen_code_t c);
    return BND_W'(1) << c;
  endfunction
endpackage

// File: rtl/bsplit_cfg_sel.sv
module bsplit_cfg_sel
  import bsplit_pkg::*;
#(
  parameter int unsigned NUM_CHIPS = 4,
  parameter int unsigned CHIP_W    = 2
) (
  input  logic [CHIP_W-1:0]      chip_i,
  input  logic [NUM_CHIPS*3-1:0] blen_i,
  input  logic [NUM_CHIPS-1:0]   align_i,
  input  logic [NUM_CHIPS*2-1:0] mw_i,
  output blen_code_t             blen_o,
  output logic                   align_o,
  output mw_code_t               mw_o
);
  blen_code_t blen_arr [NUM_CHIPS];
  mw_code_t   mw_arr   [NUM_CHIPS];

  for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_unpack
    assign blen_arr[g] = blen_i[g*3 +: 3];
    assign mw_arr[g]   = mw_i[g*2 +: 2];
  end

  always_comb begin
    blen_o  = '0;
    align_o = 1'b0;
    mw_o    = '0;
    for (int i = 0; i < NUM_CHIPS; i++) begin
      if (32'(chip_i) == 32'(i)) begin
        blen_o  = blen_arr[i];
        align_o = align_i[i];
        mw_o    = mw_arr[i];
      end
    end
  end
endmodule

// File: rtl/bsplit_ceiling.sv
module bsplit_ceiling
  import bsplit_pkg::*;
#(
  parameter int unsigned RFIFO_DEPTH = 16,
  parameter int unsigned WFIFO_DEPTH = 16,
  parameter int unsigned BEAT_W      = 16
) (
  input  logic              write_i,
  input  size_code_t        size_i,
  input  mw_code_t          mw_i,
  output logic [BEAT_W-1:0] ceil_o
);
  localparam logic [BEAT_W-1:0] RdCeil = BEAT_W'(RFIFO_DEPTH);
  localparam logic [BEAT_W-1:0] WrBase = BEAT_W'(WFIFO_DEPTH);

  logic [BEAT_W-1:0] wr_bytes, wr_beats;

  always_comb begin
    wr_bytes = WrBase << size_i;
    wr_beats = wr_bytes >> mw_i;
    if (wr_beats == '0) wr_beats = BEAT_W'(1);
    ceil_o = write_i ? wr_beats : RdCeil;
  end
endmodule

// File: rtl/bsplit_chunk.sv
module bsplit_chunk
  import bsplit_pkg::*;
#(
  parameter int unsigned BEAT_W = 16
) (
  input  logic [BEAT_W-1:0] remain_i,
  input  logic [BND_W-1:0]  addr_lsb_i,
  input  blen_code_t        blen_i,
  input  logic              align_i,
  input  logic [BEAT_W-1:0] ceil_i,
  output logic [BEAT_W-1:0] chunk_o
);
  logic [BEAT_W-1:0] lim;
  logic [BND_W-1:0]  span;
  logic [BND_W-1:0]  bl;

  always_comb begin
    bl   = blen_beats(blen_i);
    span = bl;
    lim  = remain_i;
    if (ceil_i < lim) lim = ceil_i;
    if (!blen_is_cont(blen_i)) begin
      // distance to next boundary; power-of-two length makes mod a mask
      if (align_i) span = bl - (addr_lsb_i & (bl - BND_W'(1)));
      if (BEAT_W'(span) < lim) lim = BEAT_W'(span);
    end
    chunk_o = lim;
  end
endmodule

// File: rtl/bsplit_seq.sv
module bsplit_seq
  import bsplit_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BEAT_W = 16,
  parameter int unsigned CHIP_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] word_addr_i,
  input  logic [BEAT_W-1:0] total_i,
  input  blen_code_t        blen_i,
  input  logic              align_i,
  input  logic [BEAT_W-1:0] ceil_i,
  input  logic              write_i,
  input  logic [CHIP_W-1:0] chip_i,
  input  logic              fire_i,
  input  logic [BEAT_W-1:0] chunk_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] remain_o,
  output blen_code_t        blen_o,
  output logic              align_o,
  output logic [BEAT_W-1:0] ceil_o,
  output logic              write_o,
  output logic [CHIP_W-1:0] chip_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      addr_o   <= '0;
      remain_o <= '0;
      blen_o   <= '0;
      align_o  <= 1'b0;
      ceil_o   <= '0;
      write_o  <= 1'b0;
      chip_o   <= '0;
    end else if (load_i) begin
      busy_o   <= 1'b1;
      addr_o   <= word_addr_i;
      remain_o <= total_i;
      blen_o   <= blen_i;
      align_o  <= align_i;
      ceil_o   <= ceil_i;
      write_o  <= write_i;
      chip_o   <= chip_i;
    end else if (fire_i) begin
      addr_o   <= addr_o + ADDR_W'(chunk_i);
      remain_o <= remain_o - chunk_i;
      if (remain_o == chunk_i) busy_o <= 1'b0;
    end
  end

  // R3
  chunk_fits_remain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (chunk_i != '0) && (chunk_i <= remain_o));
endmodule

// File: rtl/mem_burst_splitter.sv
module mem_burst_splitter
  import bsplit_pkg::*;
#(
  parameter int unsigned NUM_CHIPS   = 4,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned RFIFO_DEPTH = 16,
  parameter int unsigned WFIFO_DEPTH = 16,
  localparam int unsigned CHIP_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1,
  localparam int unsigned WA     = LEN_W + 8,
  localparam int unsigned WB     = $clog2(WFIFO_DEPTH + 1) + 7,
  localparam int unsigned WC     = $clog2(RFIFO_DEPTH + 1),
  localparam int unsigned WAB    = (WA > WB) ? WA : WB,
  localparam int unsigned BEAT_W = (WAB > WC) ? WAB : WC
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [LEN_W-1:0]       req_len_i,
  input  logic [2:0]             req_size_i,
  input  logic                   req_write_i,
  input  logic [CHIP_W-1:0]      req_chip_i,
  input  logic [NUM_CHIPS*3-1:0] cfg_blen_i,
  input  logic [NUM_CHIPS-1:0]   cfg_align_i,
  input  logic [NUM_CHIPS*2-1:0] cfg_mw_i,
  output logic                   cmd_valid_o,
  input  logic                   cmd_ready_i,
  output logic [ADDR_W-1:0]      cmd_addr_o,
  output logic [BEAT_W-1:0]      cmd_beats_o,
  output logic                   cmd_write_o,
  output logic [CHIP_W-1:0]      cmd_chip_o
);
  blen_code_t        sel_blen, q_blen;
  logic              sel_align, q_align;
  mw_code_t          sel_mw;
  logic [BEAT_W-1:0] sel_ceil, q_ceil, q_remain, chunk;
  logic [BEAT_W-1:0] req_bytes, req_total;
  logic [ADDR_W-1:0] word_addr, q_addr;
  logic              busy, load, fire;

  bsplit_cfg_sel #(.NUM_CHIPS(NUM_CHIPS), .CHIP_W(CHIP_W)) u_cfg (
    .chip_i (req_chip_i),
    .blen_i (cfg_blen_i),
    .align_i(cfg_align_i),
    .mw_i   (cfg_mw_i),
    .blen_o (sel_blen),
    .align_o(sel_align),
    .mw_o   (sel_mw)
  );

  bsplit_ceiling #(.RFIFO_DEPTH(RFIFO_DEPTH), .WFIFO_DEPTH(WFIFO_DEPTH), .BEAT_W(BEAT_W)) u_ceil (
    .write_i(req_write_i),
    .size_i (req_size_i),
    .mw_i   (sel_mw),
    .ceil_o (sel_ceil)
  );

  always_comb begin
    req_bytes = (BEAT_W'(req_len_i) + BEAT_W'(1)) << req_size_i;
    req_total = req_bytes >> sel_mw;
    if (req_total == '0) req_total = BEAT_W'(1);
    word_addr = req_addr_i >> sel_mw;
  end

  assign req_ready_o = !busy;
  assign load        = req_valid_i && req_ready_o;
  assign fire        = cmd_valid_o && cmd_ready_i;

  bsplit_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .CHIP_W(CHIP_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .word_addr_i(word_addr),
    .total_i    (req_total),
    .blen_i     (sel_blen),
    .align_i    (sel_align),
    .ceil_i     (sel_ceil),
    .write_i    (req_write_i),
    .chip_i     (req_chip_i),
    .fire_i     (fire),
    .chunk_i    (chunk),
    .busy_o     (busy),
    .addr_o     (q_addr),
    .remain_o   (q_remain),
    .blen_o     (q_blen),
    .align_o    (q_align),
    .ceil_o     (q_ceil),
    .write_o    (cmd_write_o),
    .chip_o     (cmd_chip_o)
  );

  bsplit_chunk #(.BEAT_W(BEAT_W)) u_chunk (
    .remain_i  (q_remain),
    .addr_lsb_i(q_addr[BND_W-1:0]),
    .blen_i    (q_blen),
    .align_i   (q_align),
    .ceil_i    (q_ceil),
    .chunk_o   (chunk)
  );

  assign cmd_valid_o = busy;
  assign cmd_addr_o  = q_addr;
  assign cmd_beats_o = chunk;

  // R10
  load_issues_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> cmd_valid_o);

  // R11
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> cmd_valid_o && $stable(cmd_addr_o)
      && $stable(cmd_beats_o) && $stable(cmd_write_o) && $stable(cmd_chip_o));

  // R2
  addr_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_ready_i) |=> !cmd_valid_o
      || (cmd_addr_o == $past(cmd_addr_o) + ADDR_W'($past(cmd_beats_o))));

  // R4
  blen_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !blen_is_cont(q_blen)) |-> cmd_beats_o <= BEAT_W'(blen_beats(q_blen)));

  // R5
  no_cross_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && q_align && !blen_is_cont(q_blen)) |->
      (BEAT_W'(q_addr[BND_W-1:0] & (blen_beats(q_blen) - BND_W'(1))) + cmd_beats_o)
        <= BEAT_W'(blen_beats(q_blen)));

  // R7
  rd_ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_write_o) |-> cmd_beats_o <= BEAT_W'(RFIFO_DEPTH));

  // R8
  wr_ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_write_o) |-> cmd_beats_o <= q_ceil);
endmodule

// File: tb/mem_burst_splitter_tb.sv
module mem_burst_splitter_tb;
  localparam int NCH = 4;
  localparam int RF  = 16;
  localparam int WF  = 16;
  localparam int BW  = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [31:0]      req_addr = '0;
  logic [7:0]       req_len = '0;
  logic [2:0]       req_size = '0;
  logic             req_write = 1'b0;
  logic [1:0]       req_chip = '0;
  logic [NCH*3-1:0] cfg_blen = '0;
  logic [NCH-1:0]   cfg_align = '0;
  logic [NCH*2-1:0] cfg_mw = '0;
  logic             cmd_valid;
  logic             cmd_ready = 1'b0;
  logic [31:0]      cmd_addr;
  logic [BW-1:0]    cmd_beats;
  logic             cmd_write;
  logic [1:0]       cmd_chip;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  mem_burst_splitter u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_size_i(req_size),
    .req_write_i(req_write), .req_chip_i(req_chip),
    .cfg_blen_i(cfg_blen), .cfg_align_i(cfg_align), .cfg_mw_i(cfg_mw),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_addr_o(cmd_addr), .cmd_beats_o(cmd_beats),
    .cmd_write_o(cmd_write), .cmd_chip_o(cmd_chip)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one descriptor; the model follows R2..R9, R12, R13
  task automatic run_case(input string req, input logic [31:0] addr, input int len,
                          input int size, input bit wr, input int chip, input int bcode,
                          input bit align, input int mw, input bit stall, input bit flip);
    int remain, waddr, ceil, lim, bl, cyc;
    bit rdy;
    cfg_blen[chip*3 +: 3] = 3'(bcode);
    cfg_align[chip]       = align;
    cfg_mw[chip*2 +: 2]   = 2'(mw);
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = addr; req_len = 8'(len);
    req_size = 3'(size); req_write = wr; req_chip = 2'(chip);
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) begin // R12: disturb config after acceptance
      cfg_blen[chip*3 +: 3] = 3'(bcode ^ 1);
      cfg_align[chip]       = ~align;
      cfg_mw[chip*2 +: 2]   = 2'(mw ^ 1);
    end
    remain = ((len + 1) << size) >> mw;
    if (remain == 0) remain = 1;
    waddr = int'(addr >> mw);
    if (wr) begin
      ceil = (WF << size) >> mw;
      if (ceil == 0) ceil = 1;
    end else ceil = RF;
    cyc = 0;
    while (remain > 0 && cyc < 4000) begin
      lim = remain;
      if (ceil < lim) lim = ceil;
      if (bcode <= 5) begin
        bl = 1 << bcode;
        if (align) bl = bl - (waddr % bl);
        if (bl < lim) lim = bl;
      end
      check(cmd_valid == 1'b1, req, "cmd valid", cmd_valid, 1);
      check(cmd_addr == 32'(waddr), req, "cmd word address", cmd_addr, waddr);
      check(int'(cmd_beats) == lim, req, "cmd beats", cmd_beats, lim);
      check(cmd_write == wr && int'(cmd_chip) == chip, "R13", "direction/chip",
            {cmd_write, cmd_chip}, {wr, 2'(chip)});
      check(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
      rdy = !stall || (cyc % 2 == 1);
      cmd_ready = rdy;
      @(negedge clk);
      if (rdy) begin
        waddr  += lim;
        remain -= lim;
      end
      cyc++;
    end
    cmd_ready = 1'b0;
    check(cmd_valid == 1'b0, "R10", "valid after last", cmd_valid, 0);
    check(req_ready == 1'b1, "R10", "ready after last", req_ready, 1);
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
    check(cmd_valid == 1'b0, "R1", "reset valid", cmd_valid, 0);
  endtask

  // 20 byte beats, burst 8, no align: 8,8,4 from 0x13
  task automatic t_unaligned();  run_case("R6",  32'h13, 19, 0, 1'b0, 0, 3, 1'b0, 0, 1'b0, 1'b0); endtask
  // same with align: 5,8,7
  task automatic t_aligned();    run_case("R5",  32'h13, 19, 0, 1'b0, 0, 3, 1'b1, 0, 1'b0, 1'b0); endtask
  // 32-bit memory, word 0x41, burst 4 aligned: 3,4,3
  task automatic t_width();      run_case("R2",  32'h104, 9, 2, 1'b0, 1, 2, 1'b1, 2, 1'b0, 1'b0); endtask
  // continuous read, align set but ignored: 4 x 16
  task automatic t_cont_read();  run_case("R9",  32'h5, 7, 3, 1'b0, 2, 6, 1'b1, 0, 1'b0, 1'b0); endtask
  // write ceiling (16<<2)>>0 = 64: 64,64
  task automatic t_wr_wide();    run_case("R8",  32'h0, 31, 2, 1'b1, 3, 7, 1'b0, 0, 1'b0, 1'b0); endtask
  // write ceiling 16 with byte beats: 16,16,8
  task automatic t_wr_narrow();  run_case("R8",  32'h40, 39, 0, 1'b1, 3, 7, 1'b0, 0, 1'b0, 1'b0); endtask
  // read ceiling with long burst 32: chunks of 16
  task automatic t_rd_ceiling(); run_case("R7",  32'h0, 47, 0, 1'b0, 1, 5, 1'b1, 0, 1'b0, 1'b0); endtask
  // stalled handshake: outputs must hold
  task automatic t_stall();      run_case("R11", 32'h3, 15, 1, 1'b1, 2, 2, 1'b1, 1, 1'b1, 1'b0); endtask
  // config changed mid-descriptor
  task automatic t_cfg_flip();   run_case("R12", 32'h6, 23, 0, 1'b0, 0, 3, 1'b1, 0, 1'b1, 1'b1); endtask
  // burst length 1: one beat per command
  task automatic t_single();     run_case("R4",  32'h9, 2, 0, 1'b1, 1, 0, 1'b0, 0, 1'b0, 1'b0); endtask
  // 64-bit memory, total (8<<3)>>3 = 8 words from 0x200: 8 in one command
  task automatic t_total();      run_case("R3",  32'h1000, 7, 3, 1'b0, 0, 7, 1'b0, 3, 1'b0, 1'b0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unaligned();
    t_aligned();
    t_width();
    t_cont_read();
    t_wr_wide();
    t_wr_narrow();
    t_rd_ceiling();
    t_stall();
    t_cfg_flip();
    t_single();
    t_total();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule